// File: doc/BRIEF.md
# Indirect Register Access Bridge

A host processor with a 16-bit data bus and a 3-bit address reaches a much larger internal register space through this bridge. A 32-bit value is first assembled in a holding register from two 16-bit host writes. Writing a target address then commits the whole value with a one-clock write strobe on the internal target bus. Reading works the same way in reverse. The host writes a read address, and the bridge pulses a one-clock read strobe. One cycle later it captures the 32-bit answer from the target bus, and the host collects it as two 16-bit halves.

Two further host locations serve the output side. One returns output data in a programmed order of up to 32 entries. The bridge gives the data path the current entry index, and the index steps forward after every read of that location. The other location returns a packed status word: a few board pins, a constant revision code, an integration-done flag and an active-low flag that shows whether unread output data is waiting.

Top module: `ireg_bridge`

## Requirements
- R1: A host write to location 0 loads holding bits 15:0, and a write to location 1 loads holding bits 31:16. Each write leaves the other half unchanged.
- R2: A host write to location 2 latches the written value as the 16-bit target address. In the next cycle `tgt_wr_stb` is high for exactly one clock, with `tgt_wdata` equal to the full holding register.
- R3: A host write to location 3 latches the target address in the same register. In the next cycle `tgt_rd_stb` is high for exactly one clock, and `tgt_wr_stb` stays low.
- R4: `tgt_rdata` is sampled on the clock edge that ends the cycle after the read strobe. Host reads at location 0 and location 1 then return captured bits 15:0 and bits 31:16.
- R5: A host read at location 3 returns a status word with these bits:
  - 15:12 are zero;
  - 11 is the inverse of `reset_pin`;
  - 10:7 are `en_in[3:0]`, with en_in[3] in bit 10;
  - 6 is `sync_in`;
  - 5:2 are the REV parameter;
  - 1 is `integ_done`;
  - 0 is the new-data flag, which is 0 while data is pending.
- R6: A host read at location 2 returns `out_data`, which the data path supplies for entry `seq_entry`. After each such read, `seq_entry` steps by one. It returns to 0 after the entry equal to `seq_last`.
- R7: After an `out_load` pulse, the new-data flag reads 0. It reads 1 after the read of entry `seq_last` has been consumed. An `out_load` in the same cycle as that read keeps the flag at 0.
- R8: Host reads at locations 0, 1 and 3 have no side effects, and only a read at location 2 moves `seq_entry`.
- R9: Host writes to locations 4 to 7 change nothing and fire no strobe. Host reads there return zero.
- R10: Reset (rst_n low) clears the holding register, the target address, the captured data, `seq_entry` and the pending state. The strobes are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write, one cycle per access |
| host_rd | input | 1 | Host read, one cycle per access |
| host_addr | input | 3 | Host location |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| tgt_addr | output | 16 | Latched indirect target address |
| tgt_wdata | output | 32 | Holding register contents |
| tgt_wr_stb | output | 1 | One-clock target write strobe |
| tgt_rd_stb | output | 1 | One-clock target read strobe |
| tgt_rdata | input | 32 | Target read data, valid the cycle after tgt_rd_stb |
| seq_entry | output | 5 | Current output sequence entry index |
| seq_last | input | 5 | Last programmed sequence entry |
| out_data | input | 16 | Output data for seq_entry |
| out_load | input | 1 | Pulse: fresh output data loaded |
| reset_pin | input | 1 | Raw reset pin level for status |
| en_in | input | 4 | Enable inputs A..D (bit 3 = A) |
| sync_in | input | 1 | Sync input |
| integ_done | input | 1 | Level detector integration done |

## Verification
A corrupted holding half or target address shows up on `tgt_wdata` or `tgt_addr` in the same cycle as the following target strobe. That is one clock after the committing host write. A read strobe that is late or missing, or a capture register loaded on the wrong cycle, makes the host's half-word reads wrong as soon as the capture delay has passed. A sequence pointer or pending bit in the wrong state changes the very next location-2 read or status read. The wrap and the flag at the last entry are therefore checked on the exact read that should trigger them.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  localparam int LOC_W = 3;

  localparam logic [LOC_W-1:0] LOC_HOLD_LO = 3'd0;
  localparam logic [LOC_W-1:0] LOC_HOLD_HI = 3'd1;
  localparam logic [LOC_W-1:0] LOC_WADDR   = 3'd2;
  localparam logic [LOC_W-1:0] LOC_RADDR   = 3'd3;

  localparam logic [LOC_W-1:0] LOC_DATA_LO = 3'd0;
  localparam logic [LOC_W-1:0] LOC_DATA_HI = 3'd1;
  localparam logic [LOC_W-1:0] LOC_SEQ     = 3'd2;
  localparam logic [LOC_W-1:0] LOC_STATUS  = 3'd3;

  localparam int STAT_W = 16;
endpackage

// File: rtl/ireg_rst_sync.sv
module ireg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  // asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ireg_host_wr.sv
module ireg_host_wr
  import ireg_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HALVES = 2,
  localparam int HOLD_W = DATA_W * HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [LOC_W-1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [HOLD_W-1:0] hold_data,
  output logic [DATA_W-1:0] iaddr,
  output logic              wr_stb,
  output logic              rd_stb
);
  logic wr_hit, rd_hit, addr_en;
  logic [DATA_W-1:0] iaddr_q;
  logic wr_stb_q, rd_stb_q;

  always_comb begin
    wr_hit  = host_wr && (host_addr == LOC_WADDR);
    rd_hit  = host_wr && (host_addr == LOC_RADDR);
    addr_en = wr_hit || rd_hit;
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic              half_en;
    logic [DATA_W-1:0] half_q;

    assign half_en = host_wr && (host_addr == LOC_W'(h));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       half_q <= '0;
      else if (half_en) half_q <= host_wdata;
    end

    assign hold_data[h*DATA_W +: DATA_W] = half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iaddr_q  <= '0;
      wr_stb_q <= 1'b0;
      rd_stb_q <= 1'b0;
    end else begin
      if (addr_en) iaddr_q <= host_wdata;
      wr_stb_q <= wr_hit;
      rd_stb_q <= rd_hit;
    end
  end

  assign iaddr  = iaddr_q;
  assign wr_stb = wr_stb_q;
  assign rd_stb = rd_stb_q;
endmodule

// File: rtl/ireg_rd_capture.sv
module ireg_rd_capture #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [WORD_W-1:0] tgt_rdata,
  output logic [WORD_W-1:0] cap_data
);
  logic              cap_en_q;
  logic [WORD_W-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en_q <= 1'b0;
      cap_q    <= '0;
    end else begin
      cap_en_q <= rd_stb;
      if (cap_en_q) cap_q <= tgt_rdata;
    end
  end

  assign cap_data = cap_q;
endmodule

// File: rtl/ireg_seq_ptr.sv
module ireg_seq_ptr #(
  parameter int SEQ_DEPTH = 32,
  localparam int PTR_W = $clog2(SEQ_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             out_load,
  input  logic [PTR_W-1:0] seq_last,
  output logic [PTR_W-1:0] ptr,
  output logic             pending
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             pend_q, pend_d;
  logic             at_last;

  always_comb begin
    at_last = (ptr_q == seq_last) || (ptr_q == PTR_W'(SEQ_DEPTH - 1));
    ptr_d   = ptr_q;
    pend_d  = pend_q;
    if (step) begin
      if (at_last) begin
        ptr_d  = '0;
        pend_d = 1'b0;
      end else begin
        ptr_d  = ptr_q + 1'b1;
      end
    end
    if (out_load) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
    end
  end

  assign ptr     = ptr_q;
  assign pending = pend_q;
endmodule

// File: rtl/ireg_status_pack.sv
module ireg_status_pack
  import ireg_pkg::*;
#(
  parameter logic [3:0] REV = 4'h6
) (
  input  logic              reset_pin,
  input  logic [3:0]        en_in,
  input  logic              sync_in,
  input  logic              integ_done,
  input  logic              pending,
  output logic [STAT_W-1:0] status
);
  always_comb begin
    status = {4'b0000, ~reset_pin, en_in, sync_in, REV, integ_done, ~pending};
  end
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
  import ireg_pkg::*;
#(
  parameter int         DATA_W    = 16,
  parameter int         SEQ_DEPTH = 32,
  parameter logic [3:0] REV       = 4'h6,
  localparam int        WORD_W    = 2 * DATA_W,
  localparam int        PTR_W     = $clog2(SEQ_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [LOC_W-1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [DATA_W-1:0] tgt_addr,
  output logic [WORD_W-1:0] tgt_wdata,
  output logic              tgt_wr_stb,
  output logic              tgt_rd_stb,
  input  logic [WORD_W-1:0] tgt_rdata,
  output logic [PTR_W-1:0]  seq_entry,
  input  logic [PTR_W-1:0]  seq_last,
  input  logic [DATA_W-1:0] out_data,
  input  logic              out_load,
  input  logic              reset_pin,
  input  logic [3:0]        en_in,
  input  logic              sync_in,
  input  logic              integ_done
);
  logic              rst_n_sync;
  logic [WORD_W-1:0] cap_data;
  logic              seq_step;
  logic              seq_pending;
  logic [STAT_W-1:0] status;

  ireg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ireg_host_wr #(.DATA_W(DATA_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .hold_data  (tgt_wdata),
    .iaddr      (tgt_addr),
    .wr_stb     (tgt_wr_stb),
    .rd_stb     (tgt_rd_stb)
  );

  ireg_rd_capture #(.WORD_W(WORD_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .rd_stb    (tgt_rd_stb),
    .tgt_rdata (tgt_rdata),
    .cap_data  (cap_data)
  );

  assign seq_step = host_rd && (host_addr == LOC_SEQ);

  ireg_seq_ptr #(.SEQ_DEPTH(SEQ_DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .step     (seq_step),
    .out_load (out_load),
    .seq_last (seq_last),
    .ptr      (seq_entry),
    .pending  (seq_pending)
  );

  ireg_status_pack #(.REV(REV)) u_stat (
    .reset_pin  (reset_pin),
    .en_in      (en_in),
    .sync_in    (sync_in),
    .integ_done (integ_done),
    .pending    (seq_pending),
    .status     (status)
  );

  always_comb begin
    case (host_addr)
      LOC_DATA_LO: host_rdata = cap_data[DATA_W-1:0];
      LOC_DATA_HI: host_rdata = cap_data[WORD_W-1:DATA_W];
      LOC_SEQ:     host_rdata = out_data;
      LOC_STATUS:  host_rdata = DATA_W'(status);
      default:     host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk
  import ireg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [LOC_W-1:0]  host_addr,
  input logic [DATA_W-1:0] host_rdata,
  input logic              tgt_wr_stb,
  input logic              tgt_rd_stb,
  input logic [PTR_W-1:0]  seq_entry,
  input logic [PTR_W-1:0]  seq_last,
  input logic              out_load,
  input logic              seq_pending
);
  assert_wr_stb_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr_stb |-> $past(host_wr && host_addr == LOC_WADDR));

  assert_rd_stb_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rd_stb |-> $past(host_wr && host_addr == LOC_RADDR));

  assert_status_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == LOC_STATUS) |-> (host_rdata[15:12] == 4'b0000));

  assert_seq_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == LOC_SEQ && seq_entry != seq_last &&
     seq_entry != {PTR_W{1'b1}})
    |=> (seq_entry == PTR_W'($past(seq_entry) + 1'b1)));

  assert_load_sets_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_load |=> seq_pending);

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && host_addr == LOC_SEQ) |=> $stable(seq_entry));

  assert_unused_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr[2] |-> (host_rdata == '0));
endmodule

bind ireg_bridge ireg_bridge_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_addr   (host_addr),
  .host_rdata  (host_rdata),
  .tgt_wr_stb  (tgt_wr_stb),
  .tgt_rd_stb  (tgt_rd_stb),
  .seq_entry   (seq_entry),
  .seq_last    (seq_last),
  .out_load    (out_load),
  .seq_pending (seq_pending)
);

// File: tb/test_ireg_bridge.sv
module test_ireg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] REV = 4'h6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd;
  logic [2:0]  host_addr;
  logic [15:0] host_wdata, host_rdata;
  logic [15:0] tgt_addr;
  logic [31:0] tgt_wdata, tgt_rdata;
  logic        tgt_wr_stb, tgt_rd_stb;
  logic [4:0]  seq_entry, seq_last;
  logic [15:0] out_data;
  logic        out_load, reset_pin, sync_in, integ_done;
  logic [3:0]  en_in;

  int n_chk = 0;
  int n_bad = 0;
  int wr_count = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ireg_bridge i_ireg_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_wr_stb(tgt_wr_stb),
    .tgt_rd_stb(tgt_rd_stb), .tgt_rdata(tgt_rdata), .seq_entry(seq_entry),
    .seq_last(seq_last), .out_data(out_data), .out_load(out_load),
    .reset_pin(reset_pin), .en_in(en_in), .sync_in(sync_in), .integ_done(integ_done)
  );

  // target model: answers one cycle after the read strobe
  always @(posedge clk) begin
    if (tgt_rd_stb) tgt_rdata <= {tgt_addr ^ 16'h5A5A, ~tgt_addr};
    if (tgt_wr_stb) wr_count <= wr_count + 1;
  end

  assign out_data = {11'h600, seq_entry};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  function automatic logic [15:0] exp_status(input logic pend);
    return {4'b0000, ~reset_pin, en_in, sync_in, REV, integ_done, ~pend};
  endfunction

  task automatic t_reset_state();
    chk("R10 strobes", {30'b0, tgt_wr_stb, tgt_rd_stb}, 32'd0);
    chk("R10 tgt_addr", {16'b0, tgt_addr}, 32'd0);
    chk("R10 holding", tgt_wdata, 32'd0);
    chk("R10 seq_entry", {27'b0, seq_entry}, 32'd0);
    host_read(3'd0, rv); chk("R10 captured lo", {16'b0, rv}, 32'd0);
    host_read(3'd3, rv); chk("R10 status idle", {16'b0, rv}, {16'b0, exp_status(1'b0)});
  endtask

  task automatic t_write_path();
    host_write(3'd0, 16'h1234);
    host_write(3'd1, 16'hABCD);
    chk("R1 holding halves", tgt_wdata, 32'hABCD_1234);
    host_write(3'd0, 16'h5555);
    chk("R1 lo only", tgt_wdata, 32'hABCD_5555);
    host_write(3'd2, 16'h0F20);
    chk("R2 strobe high", {31'b0, tgt_wr_stb}, 32'd1);
    chk("R2 tgt_addr", {16'b0, tgt_addr}, 32'h0F20);
    chk("R2 tgt_wdata", tgt_wdata, 32'hABCD_5555);
    @(negedge clk);
    chk("R2 strobe one clock", {31'b0, tgt_wr_stb}, 32'd0);
    chk("R2 one write", wr_count, 32'd1);
  endtask

  task automatic t_read_path();
    host_write(3'd3, 16'h0044);
    chk("R3 rd strobe", {31'b0, tgt_rd_stb}, 32'd1);
    chk("R3 no wr strobe", {31'b0, tgt_wr_stb}, 32'd0);
    chk("R3 tgt_addr", {16'b0, tgt_addr}, 32'h0044);
    @(negedge clk);
    chk("R3 rd strobe one clock", {31'b0, tgt_rd_stb}, 32'd0);
    @(negedge clk);
    host_read(3'd0, rv); chk("R4 lo half", {16'b0, rv}, {16'b0, ~16'h0044});
    host_read(3'd1, rv); chk("R4 hi half", {16'b0, rv}, {16'b0, 16'h0044 ^ 16'h5A5A});
    host_read(3'd0, rv); chk("R8 reread lo", {16'b0, rv}, {16'b0, ~16'h0044});
    chk("R8 ptr unmoved", {27'b0, seq_entry}, 32'd0);
  endtask

  task automatic t_status();
    reset_pin = 1'b1; en_in = 4'b1010; sync_in = 1'b1; integ_done = 1'b1;
    host_read(3'd3, rv); chk("R5 status a", {16'b0, rv}, {16'b0, exp_status(1'b0)});
    reset_pin = 1'b0; en_in = 4'b0101; sync_in = 1'b0; integ_done = 1'b0;
    host_read(3'd3, rv); chk("R5 status b", {16'b0, rv}, 32'h0000_0A99);
    chk("R8 status no step", {27'b0, seq_entry}, 32'd0);
  endtask

  task automatic t_sequence();
    seq_last = 5'd2;
    @(negedge clk); out_load = 1'b1;
    @(negedge clk); out_load = 1'b0;
    host_read(3'd3, rv); chk("R7 pending after load", {31'b0, rv[0]}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      host_read(3'd2, rv);
      chk("R6 seq data", {16'b0, rv}, 32'hC000 + i);
    end
    chk("R6 wrap to 0", {27'b0, seq_entry}, 32'd0);
    host_read(3'd3, rv); chk("R7 flag high when drained", {31'b0, rv[0]}, 32'd1);
    host_read(3'd2, rv); chk("R6 after wrap", {16'b0, rv}, 32'hC000);
    chk("R6 step", {27'b0, seq_entry}, 32'd1);
    // load in the same cycle as reading the last entry keeps pending
    seq_last = 5'd1;
    @(negedge clk);
    host_rd = 1'b1; host_addr = 3'd2; out_load = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; out_load = 1'b0;
    chk("R6 wrap at new last", {27'b0, seq_entry}, 32'd0);
    host_read(3'd3, rv); chk("R7 load wins", {31'b0, rv[0]}, 32'd0);
  endtask

  task automatic t_unused();
    logic [31:0] hold_before;
    int cnt_before;
    hold_before = tgt_wdata;
    cnt_before = wr_count;
    host_write(3'd5, 16'hDEAD);
    chk("R9 no strobe", {30'b0, tgt_wr_stb, tgt_rd_stb}, 32'd0);
    host_write(3'd6, 16'hBEEF);
    host_write(3'd7, 16'hF00D);
    host_write(3'd4, 16'hCAFE);
    chk("R9 holding unchanged", tgt_wdata, hold_before);
    chk("R9 addr unchanged", {16'b0, tgt_addr}, 32'h0044);
    chk("R9 no writes", wr_count, cnt_before);
    host_read(3'd6, rv); chk("R9 read zero", {16'b0, rv}, 32'd0);
  endtask

  task automatic t_mid_reset();
    host_read(3'd2, rv);
    chk("R6 ptr moved", {27'b0, seq_entry}, 32'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 ptr cleared", {27'b0, seq_entry}, 32'd0);
    chk("R10 holding cleared", tgt_wdata, 32'd0);
    chk("R10 addr cleared", {16'b0, tgt_addr}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    host_read(3'd1, rv); chk("R10 captured cleared", {16'b0, rv}, 32'd0);
    host_read(3'd3, rv); chk("R10 pending cleared", {31'b0, rv[0]}, 32'd1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_addr = 3'd0;
    host_wdata = 16'h0; out_load = 1'b0; seq_last = 5'd0; tgt_rdata = 32'h0;
    reset_pin = 1'b0; en_in = 4'h0; sync_in = 1'b0; integ_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_write_path();
    t_read_path();
    t_status();
    t_sequence();
    t_unused();
    t_mid_reset();
    finish_run();
  end
endmodule